// File: doc/BRIEF.md
# Burst Beat Address Sequencer for a Bus Slave

This block follows an AHB transfer stream on the slave side and keeps the address of the beat currently in its data phase. A NONSEQ beat that is selected and accepted with the ready signal high loads the start address, the burst kind and the transfer size. Each later accepted SEQ beat moves the address forward by the transfer size. Incrementing bursts step straight ahead. Wrapping bursts fold back inside an aligned window of size times beat count bytes. BUSY beats and stalled cycles leave the address unchanged.

An attached memory reads the address as a word index. The byte-lane bits are dropped and the next index bits are passed on. Fixed-length bursts are counted so that the final beat is marked. An incrementing step that would carry past the 1 kB decode boundary raises a sticky flag. The flag stays set until a new burst starts.

Top module: `ahb_beat_addr_gen`

## Requirements
- R1: While reset is held and just after it is released, `beat_addr`, `word_idx`, `active`, `last_beat` and `cross_err` are all zero.
- R2: An accepted NONSEQ beat loads `haddr`. A beat is accepted when `hsel` is 1 and `hready` is 1. NONSEQ is `htrans` = 2'b10. From the next cycle, `beat_addr` equals the loaded address and `active` is 1. `word_idx` equals `beat_addr[LANE_W+IDX_W-1:LANE_W]`, which is bits [9:2] with the default parameters.
- R3: An accepted SEQ beat (`htrans` = 2'b11) in an incrementing burst adds 2^`hsize` bytes to `beat_addr` in the next cycle. `hsize` 0 is a byte, 1 a halfword and 2 a word. Incrementing bursts are `hburst` 3'b000 SINGLE, 3'b001 INCR, 3'b011 INCR4, 3'b101 INCR8 and 3'b111 INCR16.
- R4: An accepted SEQ beat in a wrapping burst advances by the size and wraps inside an aligned window of beats × 2^size bytes. Wrapping bursts are `hburst` 3'b010 WRAP4, 3'b100 WRAP8 and 3'b110 WRAP16. Example: a WRAP4 burst of words from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: An accepted BUSY beat (`htrans` = 2'b01) changes neither the address nor the beat count.
- R6: While `hready` is 0, no beat is taken, so `beat_addr` holds.
- R7: `last_beat` is 1 exactly while the final beat of a fixed-length burst is in its data phase. A SINGLE burst is one beat and WRAPn/INCRn bursts are n beats. `last_beat` is never 1 in an INCR burst.
- R8: An accepted SEQ beat of an incrementing burst whose step carries out of address bit 9 sets `cross_err` from the next cycle. The address still advances. `cross_err` clears on the next accepted NONSEQ beat.
- R9: An accepted IDLE beat (`htrans` = 2'b00) clears `active` and `last_beat`. A SEQ beat while `active` is 0 leaves `beat_addr` unchanged.
- R10: Beats with `hsel` = 0 are ignored, and every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| hready | input | 1 | Bus ready; beats are taken only when high |
| htrans | input | 2 | Transfer type |
| hburst | input | 3 | Burst kind |
| hsize | input | 3 | Transfer size, log2 of bytes |
| haddr | input | ADDR_W | Address phase address |
| beat_addr | output | ADDR_W | Byte address of the beat in its data phase |
| word_idx | output | IDX_W | Word index for the attached memory |
| active | output | 1 | A burst is in progress |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| cross_err | output | 1 | Sticky 1 kB boundary carry flag |

## Verification
Every output is driven by a register loaded from the accepted address-phase beat. `beat_addr`, `word_idx`, `active`, `last_beat` and `cross_err` therefore show the effect of a beat one clock after the edge that takes it. The bench drives each beat on a falling edge. It waits one full cycle to the next falling edge and compares there, so each check lands in the first cycle where the new value is due. Stall, BUSY, unselected and stray SEQ beats are checked in that same cycle, to confirm that nothing moved.

// File: rtl/ahb_beat_addr_gen.sv
module ahb_beat_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int BOUND_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hready,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic [2:0]        hsize,
  input  logic [ADDR_W-1:0] haddr,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              active,
  output logic              last_beat,
  output logic              cross_err
);
  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  logic [ADDR_W-1:0] cur_q;
  logic [2:0]        kind_q;
  logic [2:0]        size_q;
  logic [3:0]        cnt_q;
  logic              act_q;
  logic              err_q;

  wire take     = hsel & hready;
  wire do_start = take && htrans == TR_NSEQ;
  wire do_step  = take && htrans == TR_SEQ && act_q;
  wire do_stop  = take && htrans == TR_IDLE;

  logic [4:0] beats;
  always_comb begin
    case (kind_q[2:1])
      2'b00:   beats = 5'd1;
      2'b01:   beats = 5'd4;
      2'b10:   beats = 5'd8;
      default: beats = 5'd16;
    endcase
  end

  wire is_wrap = ~kind_q[0] & (kind_q != 3'b000);
  wire fixed   = kind_q != 3'b001;

  wire [ADDR_W-1:0] step    = ADDR_W'(1) << size_q;
  wire [ADDR_W-1:0] span    = ADDR_W'(beats) << size_q;
  wire [ADDR_W-1:0] mask    = span - ADDR_W'(1);
  wire [ADDR_W-1:0] inc     = cur_q + step;
  wire [ADDR_W-1:0] nxt     = is_wrap ? ((cur_q & ~mask) | (inc & mask)) : inc;
  wire [BOUND_W:0]  low_sum = {1'b0, cur_q[BOUND_W-1:0]} + step[BOUND_W:0];
  wire              carry   = low_sum[BOUND_W] & ~is_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      kind_q <= '0;
      size_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (do_start) begin
      cur_q  <= haddr;
      kind_q <= hburst;
      size_q <= hsize;
      cnt_q  <= '0;
      act_q  <= 1'b1;
      err_q  <= 1'b0;
    end else if (do_step) begin
      cur_q  <= nxt;
      cnt_q  <= cnt_q + 4'd1;
      if (carry) err_q <= 1'b1;
    end else if (do_stop) begin
      act_q  <= 1'b0;
    end
  end

  assign beat_addr = cur_q;
  assign word_idx  = cur_q[LANE_W +: IDX_W];
  assign active    = act_q;
  assign last_beat = act_q & fixed & ({1'b0, cnt_q} == beats - 5'd1);
  assign cross_err = err_q;
endmodule

// File: rtl/ahb_beat_addr_gen_chk.sv
module ahb_beat_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic [2:0]        hburst,
  input logic [ADDR_W-1:0] haddr,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              active,
  input logic              last_beat,
  input logic              cross_err
);
  localparam int WIN_HI = 11;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && htrans == 2'b10) |=> (beat_addr == $past(haddr) && active));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && htrans == 2'b01) |=> $stable(beat_addr));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(beat_addr));

  // R10
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hsel |=> ($stable(beat_addr) && $stable(active) && $stable(cross_err)));

  // R4
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && htrans == 2'b11 && active && !hburst[0] && hburst != 3'b000)
    |=> beat_addr[ADDR_W-1:WIN_HI] == $past(beat_addr[ADDR_W-1:WIN_HI]));

  // R7
  last_needs_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> active);

  // R8
  err_from_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cross_err) |-> $past(htrans == 2'b11));

  // R9
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && htrans == 2'b00) |=> (!active && !last_beat));
endmodule

bind ahb_beat_addr_gen ahb_beat_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready(hready), .htrans(htrans),
  .hburst(hburst), .haddr(haddr), .beat_addr(beat_addr), .active(active),
  .last_beat(last_beat), .cross_err(cross_err)
);

// File: tb/ahb_beat_addr_gen_bench.sv
`timescale 1ns/1ps
module ahb_beat_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic        hready = 1'b1;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hburst = 3'b000;
  logic [2:0]  hsize = 3'b000;
  logic [31:0] haddr = '0;
  logic [31:0] beat_addr;
  logic [7:0]  word_idx;
  logic        active, last_beat, cross_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ahb_beat_addr_gen u_ahb_beat_addr_gen (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready(hready), .htrans(htrans),
    .hburst(hburst), .hsize(hsize), .haddr(haddr), .beat_addr(beat_addr),
    .word_idx(word_idx), .active(active), .last_beat(last_beat),
    .cross_err(cross_err)
  );

  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic s, input logic r, input logic [1:0] t,
                      input logic [2:0] b, input logic [2:0] z, input logic [31:0] a);
    hsel = s; hready = r; htrans = t; hburst = b; hsize = z; haddr = a;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 addr", beat_addr, 0);
    chk("R1 idx", 32'(word_idx), 0);
    chk("R1 flags", {29'd0, active, last_beat, cross_err}, 0);
  endtask

  task automatic t_incr_word;
    beat(1, 1, NSEQ, 3'b011, 3'd2, 32'h100);
    chk("R2 addr", beat_addr, 32'h100);
    chk("R2 idx", 32'(word_idx), 32'h40);
    chk("R2 active", 32'(active), 1);
    chk("R7 not last", 32'(last_beat), 0);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h104);
    chk("R3 word 1", beat_addr, 32'h104);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h108);
    chk("R3 word 2", beat_addr, 32'h108);
    chk("R7 not last 3rd", 32'(last_beat), 0);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h10C);
    chk("R3 word 3", beat_addr, 32'h10C);
    chk("R7 last INCR4", 32'(last_beat), 1);
  endtask

  task automatic t_incr_half_byte;
    beat(1, 1, NSEQ, 3'b001, 3'd1, 32'h202);
    beat(1, 1, SEQ, 3'b001, 3'd1, 32'h204);
    chk("R3 half", beat_addr, 32'h204);
    beat(1, 1, SEQ, 3'b001, 3'd1, 32'h206);
    chk("R3 half 2", beat_addr, 32'h206);
    chk("R7 INCR never last", 32'(last_beat), 0);
    beat(1, 1, NSEQ, 3'b101, 3'd0, 32'h11);
    beat(1, 1, SEQ, 3'b101, 3'd0, 32'h12);
    chk("R3 byte", beat_addr, 32'h12);
  endtask

  task automatic t_wrap4;
    logic [31:0] exp [4] = '{32'h34, 32'h38, 32'h3C, 32'h30};
    beat(1, 1, NSEQ, 3'b010, 3'd2, 32'h34);
    chk("R4 wrap4 start", beat_addr, exp[0]);
    for (int i = 1; i < 4; i++) begin
      beat(1, 1, SEQ, 3'b010, 3'd2, exp[i]);
      chk("R4 wrap4", beat_addr, exp[i]);
    end
    chk("R7 last WRAP4", 32'(last_beat), 1);
  endtask

  task automatic t_wrap8_half;
    logic [31:0] exp [8] = '{32'h1C, 32'h1E, 32'h10, 32'h12, 32'h14, 32'h16, 32'h18, 32'h1A};
    beat(1, 1, NSEQ, 3'b100, 3'd1, 32'h1C);
    for (int i = 1; i < 8; i++) begin
      beat(1, 1, SEQ, 3'b100, 3'd1, exp[i]);
      chk("R4 wrap8 half", beat_addr, exp[i]);
    end
    chk("R7 last WRAP8", 32'(last_beat), 1);
  endtask

  task automatic t_busy;
    beat(1, 1, NSEQ, 3'b011, 3'd2, 32'h40);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h44);
    beat(1, 1, BUSY, 3'b011, 3'd2, 32'h48);
    chk("R5 busy holds", beat_addr, 32'h44);
    beat(1, 1, BUSY, 3'b011, 3'd2, 32'h48);
    chk("R5 busy holds 2", beat_addr, 32'h44);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h48);
    chk("R5 after busy", beat_addr, 32'h48);
    chk("R5 count held", 32'(last_beat), 0);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h4C);
    chk("R5 last after busy", 32'(last_beat), 1);
  endtask

  task automatic t_stall;
    beat(1, 1, NSEQ, 3'b001, 3'd2, 32'h80);
    beat(1, 0, SEQ, 3'b001, 3'd2, 32'h84);
    chk("R6 seq stalled", beat_addr, 32'h80);
    beat(1, 0, NSEQ, 3'b001, 3'd2, 32'h300);
    chk("R6 nseq stalled", beat_addr, 32'h80);
    beat(1, 1, SEQ, 3'b001, 3'd2, 32'h84);
    chk("R6 resumes", beat_addr, 32'h84);
  endtask

  task automatic t_single;
    beat(1, 1, NSEQ, 3'b000, 3'd2, 32'h200);
    chk("R7 single last", 32'(last_beat), 1);
  endtask

  task automatic t_cross;
    beat(1, 1, NSEQ, 3'b001, 3'd2, 32'h3F8);
    beat(1, 1, SEQ, 3'b001, 3'd2, 32'h3FC);
    chk("R8 no err yet", 32'(cross_err), 0);
    beat(1, 1, SEQ, 3'b001, 3'd2, 32'h400);
    chk("R8 err set", 32'(cross_err), 1);
    chk("R8 addr advanced", beat_addr, 32'h400);
    beat(1, 1, IDLE, 3'b001, 3'd2, 32'h0);
    chk("R8 err sticky", 32'(cross_err), 1);
    beat(1, 1, NSEQ, 3'b001, 3'd2, 32'h10);
    chk("R8 err cleared", 32'(cross_err), 0);
    beat(1, 1, NSEQ, 3'b010, 3'd2, 32'h3FC);
    beat(1, 1, SEQ, 3'b010, 3'd2, 32'h3F0);
    chk("R8 wrap no err", 32'(cross_err), 0);
  endtask

  task automatic t_idle;
    beat(1, 1, NSEQ, 3'b011, 3'd2, 32'h500);
    beat(1, 1, IDLE, 3'b000, 3'd0, 32'h0);
    chk("R9 inactive", 32'(active), 0);
    beat(1, 1, SEQ, 3'b011, 3'd2, 32'h504);
    chk("R9 stray seq", beat_addr, 32'h500);
  endtask

  task automatic t_unsel;
    beat(0, 1, NSEQ, 3'b011, 3'd2, 32'h700);
    chk("R10 unsel addr", beat_addr, 32'h500);
    chk("R10 unsel active", 32'(active), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_incr_word();
    t_incr_half_byte();
    t_wrap4();
    t_wrap8_half();
    t_busy();
    t_stall();
    t_single();
    t_cross();
    t_idle();
    t_unsel();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule